// File: doc/BRIEF.md
# Masked Pseudo-Random Noise Adder for a Multi-Channel DAC

This block produces the digital output code of each converter channel when that channel runs in noise mode. Each channel has a 12-bit holding value, a trigger-enable bit, a 2-bit wave mode and a 4-bit amplitude field. A trigger is accepted when its enable bit is set. In noise mode an accepted trigger adds the low bits of the channel's own linear-feedback shift register to the holding value. The amplitude field chooses how many of those low bits are used. The carry out of the top bit is dropped. The 12-bit result reaches the channel's output code a fixed number of clock cycles later. The LFSR steps once for every accepted noise trigger.

In any other wave mode an accepted trigger copies the holding value unchanged and leaves the LFSR alone. When no trigger is accepted, the output code keeps its last value. A shared-mask input makes every channel use channel 0's amplitude field, so the channels can run under one common noise amplitude. Each LFSR still produces its own sequence.

Top module: `noise_dac_adder`

## Requirements
- R1: While reset is held and on the first cycle after it, every output code is 0. Channel c's LFSR starts from the nonzero seed 12'hACE + c.
- R2: With wave mode 2'b01 (noise), an accepted trigger loads the output code with hold + (lfsr & mask). The lfsr value is the register contents before the step caused by that trigger.
- R3: A trigger sampled at clock edge k changes the output code at edge k+3. At edges k+1 and k+2 the code still shows its previous value.
- R4: The LFSR steps once per accepted noise trigger as a 12-bit left shift. Bit 0 takes in the XOR of bits 11, 5, 3 and 0. It never reaches zero.
- R5: Amplitude value n passes LFSR bits [n:0]. Every value of 11 or more passes all 12 bits.
- R6: The sum is taken modulo 4096: the carry out of bit 11 is discarded.
- R7: A trigger with its enable bit low leaves both the output code and the LFSR unchanged.
- R8: With a wave mode other than 2'b01, an accepted trigger loads the plain holding value and does not step the LFSR.
- R9: Each channel has its own LFSR. A trigger on one channel does not step another channel's LFSR.
- R10: With the shared-mask input high, every channel uses channel 0's amplitude field. With it low, each channel uses its own field.
- R11: Triggers on consecutive cycles each produce their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wave_mode_i | input | 2*NCH | Per-channel wave mode, 2'b01 selects noise |
| trig_en_i | input | NCH | Per-channel trigger enable |
| trig_i | input | NCH | Per-channel trigger pulse, one cycle per event |
| hold_i | input | 12*NCH | Per-channel holding value |
| amp_i | input | 4*NCH | Per-channel amplitude (mask width) field |
| amp_shared_i | input | 1 | Use channel 0's amplitude field for all channels |
| code_o | output | 12*NCH | Per-channel output code |

## Verification
Every result is due on the third rising edge after the edge that samples the trigger. The bench raises a trigger for one cycle at a falling edge. It then reads the code at the falling edges after the first, second and third rising edges. The code must still hold its old value at the second read and the new value at the third. The bench computes the expected code and the LFSR sequence of each channel arithmetically, at the moment of the trigger. The hold and amplitude values used are the ones present on that edge. In the consecutive-trigger test one result is due on each falling edge after the third rising edge, and the bench reads one per cycle.

// File: rtl/dac_noise_pkg.sv
// Package: shared types and constants for the noise adder.
// Assumes: 12-bit codes and a 4-bit amplitude field by default.
package dac_noise_pkg;

    // Wave mode encoding; only WAVE_NOISE adds LFSR bits.
    typedef enum logic [1:0] {
        WAVE_NONE  = 2'b00,
        WAVE_NOISE = 2'b01,
        WAVE_TRI   = 2'b10,
        WAVE_RSVD  = 2'b11
    } wave_mode_e;

    localparam int CODE_W      = 12;
    localparam int AMP_W       = 4;
    localparam int XFER_DELAY  = 3;
    localparam logic [CODE_W-1:0] LFSR_TAPS = 12'h829; // bits 11,5,3,0
    localparam logic [CODE_W-1:0] LFSR_SEED = 12'hACE;

endpackage

// File: rtl/noise_lfsr.sv
// Module: noise_lfsr
// Fibonacci LFSR that shifts left and feeds the XOR of the tap bits into
// bit 0. It steps only when step_i is high.
// Assumes: TAPS describe a maximal-length polynomial; SEED is nonzero.
module noise_lfsr #(
    parameter int              W    = 12,
    parameter logic [W-1:0]    TAPS = 12'h829,
    parameter logic [W-1:0]    SEED = 12'hACE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_q;
    logic         feedback;

    // Feedback bit: parity of the tapped positions.
    always_comb begin
        feedback = ^(state_q & TAPS);
    end

    // State register: load seed on reset, shift on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step_i) begin
            state_q <= {state_q[W-2:0], feedback};
        end
    end

    assign state_o = state_q;

    // R4: a maximal-length register never falls into the all-zero state.
    p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R7 / R8 / R9: the register moves only when asked to.
    p_lfsr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(state_q));

    // R4: a step always changes the state (no fixed point besides zero).
    p_lfsr_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> !$stable(state_q));

endmodule

// File: rtl/noise_amp_mask.sv
// Module: noise_amp_mask
// Turns the amplitude field into a contiguous low-order bit mask. Bit i is
// set when the field is at least i, so value n passes bits [n:0] and any
// value of W-1 or more passes every bit.
// Assumes: W <= 2**AW.
module noise_amp_mask #(
    parameter int W  = 12,
    parameter int AW = 4
) (
    input  logic [AW-1:0] amp_i,
    output logic [W-1:0]  mask_o
);

    // One comparator per mask bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            mask_o[i] = (int'(amp_i) >= i);
        end
    end

endmodule

// File: rtl/noise_xfer_pipe.sv
// Module: noise_xfer_pipe
// Fixed-latency delay line that carries a pending code and its valid flag
// from the trigger edge towards the output register.
// Assumes: DEPTH >= 1.
module noise_xfer_pipe #(
    parameter int W     = 12,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [W-1:0] data_i,
    output logic         valid_o,
    output logic [W-1:0] data_o
);

    logic [DEPTH-1:0] vld_q;
    logic [W-1:0]     dat_q [DEPTH];

    // Stage 0: capture the new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            dat_q[0] <= '0;
        end else begin
            vld_q[0] <= valid_i;
            dat_q[0] <= data_i;
        end
    end

    // Later stages: shift the request along one stage per cycle.
    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                dat_q[s] <= '0;
            end else begin
                vld_q[s] <= vld_q[s-1];
                dat_q[s] <= dat_q[s-1];
            end
        end

        // R11: every request advances exactly one stage per cycle.
        p_stage_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[s-1] |=> (vld_q[s] && dat_q[s] == $past(dat_q[s-1])));
    end

    assign valid_o = vld_q[DEPTH-1];
    assign data_o  = dat_q[DEPTH-1];

endmodule

// File: rtl/noise_channel.sv
// Module: noise_channel
// One converter channel: it accepts triggers, forms hold plus masked LFSR
// (or the plain hold value outside noise mode), delays the result and
// holds it in the output code register.
// Assumes: trig_i is a one-cycle pulse per event; inputs are synchronous.
module noise_channel
    import dac_noise_pkg::*;
#(
    parameter int                W     = 12,
    parameter int                AW    = 4,
    parameter int                DELAY = 3,
    parameter logic [W-1:0]      TAPS  = 12'h829,
    parameter logic [W-1:0]      SEED  = 12'hACE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wave_mode_e    mode_i,
    input  logic          trig_en_i,
    input  logic          trig_i,
    input  logic [W-1:0]  hold_i,
    input  logic [AW-1:0] amp_i,
    output logic [W-1:0]  code_o
);

    logic         accept;
    logic         noise_step;
    logic [W-1:0] lfsr_val;
    logic [W-1:0] amp_mask;
    logic [W-1:0] noise_sum;
    logic [W-1:0] payload;
    logic         pipe_vld;
    logic [W-1:0] pipe_dat;
    logic [W-1:0] code_q;

    // Trigger acceptance and LFSR step decision.
    always_comb begin
        accept     = trig_i & trig_en_i;
        noise_step = accept & (mode_i == WAVE_NOISE);
    end

    noise_lfsr #(
        .W    (W),
        .TAPS (TAPS),
        .SEED (SEED)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (noise_step),
        .state_o (lfsr_val)
    );

    noise_amp_mask #(
        .W  (W),
        .AW (AW)
    ) u_mask (
        .amp_i  (amp_i),
        .mask_o (amp_mask)
    );

    // Wrapped sum of hold and masked noise; carry out is discarded.
    always_comb begin
        noise_sum = hold_i + (lfsr_val & amp_mask);
        payload   = (mode_i == WAVE_NOISE) ? noise_sum : hold_i;
    end

    noise_xfer_pipe #(
        .W     (W),
        .DEPTH (DELAY)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (accept),
        .data_i  (payload),
        .valid_o (pipe_vld),
        .data_o  (pipe_dat)
    );

    // Output code register: loads only when a delayed request arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (pipe_vld) begin
            code_q <= pipe_dat;
        end
    end

    assign code_o = code_q;

    // R7: without an arriving request the output code holds.
    p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_vld |=> $stable(code_q));

    // R5: the amplitude mask is always a contiguous run of low ones.
    p_mask_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        amp_mask[0] && (((amp_mask + 1'b1) & amp_mask) == '0));

    // R8: outside noise mode an accepted trigger passes the hold value through.
    p_plain_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_i != WAVE_NOISE) |=> (u_pipe.dat_q[0] == $past(hold_i)));

endmodule

// File: rtl/noise_dac_adder.sv
// Module: noise_dac_adder (top)
// Array of NCH noise channels, each with its own LFSR and seed. One input
// can force every channel to use channel 0's amplitude field.
// Assumes: CODE width 12 and amplitude width 4 by default; seeds per
// channel are SEED + c and must be nonzero.
module noise_dac_adder
    import dac_noise_pkg::*;
#(
    parameter int                 NCH   = 2,
    parameter int                 W     = CODE_W,
    parameter int                 AW    = AMP_W,
    parameter int                 DELAY = XFER_DELAY,
    parameter logic [W-1:0]       TAPS  = LFSR_TAPS,
    parameter logic [W-1:0]       SEED  = LFSR_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*NCH-1:0]  wave_mode_i,
    input  logic [NCH-1:0]    trig_en_i,
    input  logic [NCH-1:0]    trig_i,
    input  logic [W*NCH-1:0]  hold_i,
    input  logic [AW*NCH-1:0] amp_i,
    input  logic              amp_shared_i,
    output logic [W*NCH-1:0]  code_o
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [W-1:0] CH_SEED = SEED + W'(c);

        logic [AW-1:0] amp_sel;
        wave_mode_e    mode;

        // Amplitude selection: shared field or the channel's own.
        always_comb begin
            amp_sel = amp_shared_i ? amp_i[AW-1:0] : amp_i[c*AW +: AW];
            mode    = wave_mode_e'(wave_mode_i[c*2 +: 2]);
        end

        noise_channel #(
            .W     (W),
            .AW    (AW),
            .DELAY (DELAY),
            .TAPS  (TAPS),
            .SEED  (CH_SEED)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_i    (mode),
            .trig_en_i (trig_en_i[c]),
            .trig_i    (trig_i[c]),
            .hold_i    (hold_i[c*W +: W]),
            .amp_i     (amp_sel),
            .code_o    (code_o[c*W +: W])
        );

        // R1: the output code is zero on the first cycle after reset.
        p_reset_zero_r1: assert property (@(posedge clk)
            !rst_n |=> (code_o[c*W +: W] == '0));

        // R10: with sharing on, channel c sees channel 0's field.
        p_shared_amp_r10: assert property (@(posedge clk) disable iff (!rst_n)
            amp_shared_i |-> (amp_sel == amp_i[AW-1:0]));
    end

endmodule

// File: tb/noise_dac_adder_tb.sv
module noise_dac_adder_tb;

    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  wave_mode = '0;
    logic [1:0]  trig_en = '0;
    logic [1:0]  trig = '0;
    logic [23:0] hold = '0;
    logic [7:0]  amp = '0;
    logic        amp_shared = 1'b0;
    logic [23:0] code;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [11:0] m_lfsr [NCH];
    logic [11:0] m_code [NCH];

    always #2 clk = ~clk; // 250 MHz

    noise_dac_adder #(.NCH(NCH)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wave_mode_i  (wave_mode),
        .trig_en_i    (trig_en),
        .trig_i       (trig),
        .hold_i       (hold),
        .amp_i        (amp),
        .amp_shared_i (amp_shared),
        .code_o       (code)
    );

    function automatic logic [11:0] lfsr_next(input logic [11:0] s);
        return {s[10:0], s[11] ^ s[5] ^ s[3] ^ s[0]};
    endfunction

    function automatic logic [11:0] mask_of(input int n);
        if (n >= 11) return 12'hFFF;
        return 12'((13'd1 << (n + 1)) - 13'd1);
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model one trigger edge on the channels in tr; returns new expected codes.
    task automatic model_edge(input logic [1:0] tr, output logic [11:0] nv [NCH]);
        for (int c = 0; c < NCH; c++) begin
            int a;
            a = amp_shared ? int'(amp[3:0]) : int'(amp[c*4 +: 4]);
            nv[c] = m_code[c];
            if (tr[c] && trig_en[c]) begin
                if (wave_mode[c*2 +: 2] == 2'b01) begin
                    nv[c] = hold[c*12 +: 12] + (m_lfsr[c] & mask_of(a));
                    m_lfsr[c] = lfsr_next(m_lfsr[c]);
                end else begin
                    nv[c] = hold[c*12 +: 12];
                end
            end
        end
    endtask

    // Single trigger with latency check (R3) and result check under tag.
    task automatic fire(input logic [1:0] tr, input string tag);
        logic [11:0] nv [NCH];
        trig = tr;
        model_edge(tr, nv);
        @(posedge clk);
        @(negedge clk) trig = '0;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) check("R3 old value held", code[c*12 +: 12], m_code[c]);
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            check(tag, code[c*12 +: 12], nv[c]);
            m_code[c] = nv[c];
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [11:0] hv [4];
        hv[0] = 12'h000; hv[1] = 12'h123; hv[2] = 12'h800; hv[3] = 12'hF00;
        for (int c = 0; c < NCH; c++) begin
            m_lfsr[c] = 12'(12'hACE + c);
            m_code[c] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset code ch0", code[11:0], 12'h000);
        check("R1 reset code ch1", code[23:12], 12'h000);

        // R2 R5 R9: sweep amplitudes and holds on both channels together.
        wave_mode = 4'b0101;
        trig_en = 2'b11;
        for (int m = 0; m < 16; m++) begin
            for (int h = 0; h < 4; h++) begin
                amp = {4'(15 - m), 4'(m)};
                hold = {~hv[h], hv[h]};
                fire(2'b11, "R2 R5 masked noise sum");
            end
        end

        // R6: carry out of bit 11 is dropped.
        hold = {12'hFFF, 12'hFFF};
        amp = 8'hBB;
        for (int i = 0; i < 4; i++) fire(2'b11, "R6 wrapped sum");

        // R4: with hold 0 and full mask the code traces the LFSR sequence.
        hold = '0;
        for (int i = 0; i < 8; i++) fire(2'b01, "R4 lfsr sequence");

        // R7: disabled trigger changes nothing; next enabled one uses the unstepped LFSR.
        hold = {12'h0AA, 12'h055};
        trig_en = 2'b00;
        fire(2'b11, "R7 disabled trigger ignored");
        trig_en = 2'b11;
        fire(2'b11, "R7 lfsr not stepped by disabled trigger");

        // R8: other modes copy hold and leave the LFSR alone.
        wave_mode = 4'b0010;
        hold = {12'h321, 12'h456};
        fire(2'b11, "R8 plain copy modes 00/10");
        wave_mode = 4'b1111;
        hold = {12'h777, 12'h888};
        fire(2'b11, "R8 plain copy mode 11");
        wave_mode = 4'b0101;
        hold = '0;
        fire(2'b11, "R8 lfsr unchanged after plain copies");

        // R9: channel 1 alone; channel 0 keeps its place in the sequence.
        for (int i = 0; i < 5; i++) fire(2'b10, "R9 channel 1 only");
        fire(2'b01, "R9 channel 0 unaffected");

        // R10: shared amplitude field from channel 0.
        amp = {4'hF, 4'h2};
        amp_shared = 1'b1;
        for (int i = 0; i < 4; i++) fire(2'b11, "R10 shared mask");
        amp_shared = 1'b0;
        fire(2'b11, "R10 separate masks");

        // R11: three consecutive triggers on channel 0.
        begin
            logic [11:0] nv [NCH];
            logic [11:0] e [3];
            amp = 8'hBB;
            for (int i = 0; i < 3; i++) begin
                hold[11:0] = 12'(12'h100 * (i + 1));
                trig = 2'b01;
                model_edge(2'b01, nv);
                e[i] = nv[0];
                @(posedge clk);
                @(negedge clk);
            end
            trig = '0;
            check("R11 old value before burst", code[11:0], m_code[0]);
            for (int i = 0; i < 3; i++) begin
                @(posedge clk);
                @(negedge clk);
                check("R11 burst result", code[11:0], e[i]);
            end
            m_code[0] = e[2];
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule